// File: doc/BRIEF.md
# Dual-Compare Programmable Timer

This block is an up-counting timer with two compare values, a control word, an input pin and an output pin. Each qualified tick advances the count. When the next count would equal the active compare value, the count returns to zero instead, and the block flags a terminal event. The tick comes from one of three sources. It can be every fourth system clock, a prescale tick supplied by a neighbouring timer, or synchronised rising edges on the input pin. When the tick is internal, the input pin either gates counting or restarts the count on its rising edge.

A control state machine runs the block. Its states are `ST_IDLE` (stopped), `ST_PHASE_A` (counting against compare A) and `ST_PHASE_B` (counting against compare B). The transitions are:
- enable: `ST_IDLE` to `ST_PHASE_A`.
- disable: either running state to `ST_IDLE`.
- swap: `ST_PHASE_A` to `ST_PHASE_B` on a terminal event in alternating mode.
- wrap: `ST_PHASE_B` to `ST_PHASE_A` on a terminal event when continuous.
- finish: a running state to `ST_IDLE` on a terminal event that ends a one-shot.

Single-compare mode produces a low pulse on the output at each terminal event. Alternating mode produces a waveform whose duty cycle is set by the two compare values. A sticky flag and an interrupt request record terminal events. A one-clock terminal pulse lets the block drive another timer's prescale input.

Software accesses the block through a one-cycle write port, where `wr_sel` picks the target: 0 control, 1 compare A, 2 compare B, 3 count. The read port is combinational and uses the same selection code.

Control word bits:
- bit 0: continuous.
- bit 1: alternating.
- bit 2: external clock.
- bit 3: prescale source.
- bit 4: retrigger.
- bit 5: max-count flag.
- bit 6: interrupt enable.
- bit 7: phase, read-only (1 in `ST_PHASE_B`).
- bit 14: enable-write key, reads 0.
- bit 15: running, reads 1 in either running state.

Top module: `dc_timer`

## Requirements
- R1: When running, each qualified tick adds one to the count. If count+1 (modulo 2^16) equals the active compare value, the count becomes 0 and a terminal event occurs. Compare value 2 gives count states 0 and 1. Compare value 0 gives 65,536 states.
- R2: When the alternating bit (bit 1) is set, a terminal event in `ST_PHASE_A` moves to `ST_PHASE_B`, which counts against compare B. Control bit 7 reads 1 exactly while in `ST_PHASE_B`.
- R3: `tmr_out` depends on the mode. With bit 1 set, it is 1 outside `ST_PHASE_B` and 0 in `ST_PHASE_B`. With bit 1 clear, it is 0 for the one clock after a terminal event and 1 otherwise.
- R4: With bit 0 clear (one-shot), the timer returns to `ST_IDLE` at the terminal event. In single-compare mode this is the terminal event of `ST_PHASE_A`; in alternating mode it is the terminal event of `ST_PHASE_B`. The count is left at 0.
- R5: A control write changes the running state only when bit 14 of that write is 1. Setting bit 15 from `ST_IDLE` enters `ST_PHASE_A`. Clearing bit 15 enters `ST_IDLE`. A write with bit 14 clear leaves the state unchanged.
- R6: Control bit 5 sets on every terminal event. It stays set until a control write carries 0 in bit 5. Writing 1 to bit 5 leaves it unchanged.
- R7: When bit 6 is set, a terminal event raises `irq`. `irq` stays high, even after a disable, until `irq_ack`. A terminal event in the same cycle as `irq_ack` wins.
- R8: The tick source is chosen as follows. With bit 2 set, the tick is a rising edge of `tmr_in`, seen after a two-flop synchroniser and one more edge flop. With bit 2 clear, the tick is `pre_tick` if bit 3 is set, or every fourth system clock after reset if bit 3 is clear.
- R9: With internal ticks and bit 4 clear, counting happens only while the synchronised `tmr_in` is high. With bit 4 set, a synchronised rising edge of `tmr_in` clears the count to 0 while running, takes priority over a tick, and causes no terminal event.
- R10: `tc_pulse` is high for exactly the one clock after each terminal event.
- R11: After reset, the control word reads 0, both compare values and the count read 0, the state is `ST_IDLE`, `tmr_out` is 1, and `irq` and `tc_pulse` are 0.
- R12: A write loads the register chosen by `wr_sel`. Any tick or retrigger that falls in a write cycle is dropped. `rd_data` shows the register chosen by `rd_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 control, 1 compare A, 2 compare B, 3 count |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read selection, same coding as wr_sel |
| rd_data | output | 16 | Selected register value |
| tmr_in | input | 1 | Asynchronous input pin: clock, gate or retrigger |
| pre_tick | input | 1 | Prescale tick from another timer |
| irq_ack | input | 1 | Clears the pending interrupt request |
| tmr_out | output | 1 | Waveform output pin |
| irq | output | 1 | Pending interrupt request |
| tc_pulse | output | 1 | One-clock pulse after each terminal event |

## Verification
The assertions rely on three assumptions:
- Writes and ticks never overlap.
- A terminal event is never immediately followed by a counting step in the same cycle as a write.
- `irq_ack` is only ever a short pulse.

The design itself ensures the first of these by dropping ticks in write cycles. The bench drives every input on the falling edge, so all inputs are stable when the design samples them. It holds each write strobe for exactly one cycle. It toggles `tmr_in` at intervals of several clocks, so the synchroniser always sees clean levels. A behavioural model runs alongside and is compared against all outputs on every cycle, including a full 65,536-state wrap driven by a constant prescale tick.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int CB_CONT  = 0;
    localparam int CB_ALT   = 1;
    localparam int CB_EXT   = 2;
    localparam int CB_PRE   = 3;
    localparam int CB_RTG   = 4;
    localparam int CB_MC    = 5;
    localparam int CB_IEN   = 6;
    localparam int CB_PHASE = 7;
    localparam int CB_INH   = 14;
    localparam int CB_RUN   = 15;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_CMPA  = 2'd1;
    localparam logic [1:0] SEL_CMPB  = 2'd2;
    localparam logic [1:0] SEL_COUNT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PHASE_A = 2'd1,
        ST_PHASE_B = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic ien;
        logic rtg;
        logic pre;
        logic ext;
        logic alt;
        logic cont;
    } tmr_cfg_t;

endpackage

// File: rtl/dct_pin_sync.sv
module dct_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] sh_q;

    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh_q[g] <= 1'b0;
                    else        sh_q[g] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh_q[g] <= 1'b0;
                    else        sh_q[g] <= sh_q[g-1];
                end
            end
        end
    endgenerate

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/dct_tick_sel.sv
module dct_tick_sel
    import dct_pkg::*;
#(
    parameter int DIV_LOG2 = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  tmr_cfg_t cfg,
    input  logic     pre_tick,
    input  logic     pin_level,
    input  logic     pin_rise,
    output logic     tick,
    output logic     retrig
);
    logic [DIV_LOG2-1:0] div_q;
    logic                div_tick;
    logic                base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign div_tick = &div_q;
    assign base     = cfg.pre ? pre_tick : div_tick;

    always_comb begin
        tick   = 1'b0;
        retrig = 1'b0;
        if (cfg.ext) begin
            tick = pin_rise;
        end else if (cfg.rtg) begin
            tick   = base;
            retrig = pin_rise;
        end else begin
            tick = base & pin_level;
        end
    end

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> !div_tick); // R8

endmodule

// File: rtl/dct_core.sv
module dct_core
    import dct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    input  logic         retrig,
    input  logic         irq_ack,
    output tmr_cfg_t     cfg,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cmp_a,
    output logic [W-1:0] cmp_b,
    output logic         running,
    output logic         phase_b,
    output logic         mc,
    output logic         irq,
    output logic         tc,
    output logic         tmr_out
);
    localparam logic [W-1:0] ONE = W'(1);

    tmr_state_e   st_q, st_d;
    tmr_cfg_t     cfg_q;
    logic [W-1:0] cnt_q, cmp_a_q, cmp_b_q, active_cmp;
    logic         mc_q, irq_q, tc_q;
    logic         wr_ctrl, key, run_req, step, hit, clr;

    assign wr_ctrl    = wr_en && (wr_sel == SEL_CTRL);
    assign key        = wr_ctrl && wr_data[CB_INH];
    assign run_req    = wr_data[CB_RUN];
    assign running    = (st_q != ST_IDLE);
    assign active_cmp = (st_q == ST_PHASE_B) ? cmp_b_q : cmp_a_q;
    assign clr        = running && !wr_en && retrig;
    assign step       = running && !wr_en && !retrig && tick;
    assign hit        = step && ((cnt_q + ONE) == active_cmp);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (key && run_req) st_d = ST_PHASE_A;          // enable
            end
            ST_PHASE_A: begin
                if (key && !run_req)  st_d = ST_IDLE;           // disable
                else if (hit) begin
                    if (cfg_q.alt)       st_d = ST_PHASE_B;     // swap
                    else if (!cfg_q.cont) st_d = ST_IDLE;       // finish
                end
            end
            ST_PHASE_B: begin
                if (key && !run_req)  st_d = ST_IDLE;           // disable
                else if (hit)         st_d = cfg_q.cont ? ST_PHASE_A : ST_IDLE; // wrap / finish
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            cnt_q   <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
            mc_q    <= 1'b0;
            irq_q   <= 1'b0;
            tc_q    <= 1'b0;
        end else begin
            tc_q <= hit;
            if (wr_ctrl) begin
                cfg_q.cont <= wr_data[CB_CONT];
                cfg_q.alt  <= wr_data[CB_ALT];
                cfg_q.ext  <= wr_data[CB_EXT];
                cfg_q.pre  <= wr_data[CB_PRE];
                cfg_q.rtg  <= wr_data[CB_RTG];
                cfg_q.ien  <= wr_data[CB_IEN];
            end
            if (wr_en && wr_sel == SEL_CMPA) cmp_a_q <= wr_data;
            if (wr_en && wr_sel == SEL_CMPB) cmp_b_q <= wr_data;
            if (wr_en && wr_sel == SEL_COUNT) cnt_q <= wr_data;
            else if (clr || hit)              cnt_q <= '0;
            else if (step)                    cnt_q <= cnt_q + ONE;
            if (hit)                                  mc_q <= 1'b1;
            else if (wr_ctrl && !wr_data[CB_MC])      mc_q <= 1'b0;
            if (hit && cfg_q.ien) irq_q <= 1'b1;
            else if (irq_ack)     irq_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        cfg     = cfg_q;
        cnt     = cnt_q;
        cmp_a   = cmp_a_q;
        cmp_b   = cmp_b_q;
        phase_b = (st_q == ST_PHASE_B);
        mc      = mc_q;
        irq     = irq_q;
        tc      = tc_q;
        tmr_out = cfg_q.alt ? (st_q != ST_PHASE_B) : !tc_q;
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q |-> (cnt_q == '0)); // R1
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q && !$past(cfg_q.cont) && !$past(cfg_q.alt) |-> (st_q == ST_IDLE)); // R4
    AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && !wr_data[CB_INH] |=> (running == $past(running))); // R5
    AST_MC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mc_q && !(wr_ctrl && !wr_data[CB_MC]) |=> mc_q); // R6
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !irq_ack |=> irq_q); // R7
    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tc_q); // R12

endmodule

// File: rtl/dc_timer.sv
module dc_timer
    import dct_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LOG2    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    input  logic         tmr_in,
    input  logic         pre_tick,
    input  logic         irq_ack,
    output logic         tmr_out,
    output logic         irq,
    output logic         tc_pulse
);
    tmr_cfg_t     cfg;
    logic [W-1:0] cnt, cmp_a, cmp_b, ctrl_rd;
    logic         pin_level, pin_rise, tick, retrig;
    logic         running, phase_b, mc;

    dct_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(tmr_in),
        .level(pin_level), .rise(pin_rise)
    );

    dct_tick_sel #(.DIV_LOG2(DIV_LOG2)) u_tick (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .pre_tick(pre_tick),
        .pin_level(pin_level), .pin_rise(pin_rise),
        .tick(tick), .retrig(retrig)
    );

    dct_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick(tick), .retrig(retrig), .irq_ack(irq_ack),
        .cfg(cfg), .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .running(running), .phase_b(phase_b), .mc(mc), .irq(irq),
        .tc(tc_pulse), .tmr_out(tmr_out)
    );

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[CB_CONT]  = cfg.cont;
        ctrl_rd[CB_ALT]   = cfg.alt;
        ctrl_rd[CB_EXT]   = cfg.ext;
        ctrl_rd[CB_PRE]   = cfg.pre;
        ctrl_rd[CB_RTG]   = cfg.rtg;
        ctrl_rd[CB_MC]    = mc;
        ctrl_rd[CB_IEN]   = cfg.ien;
        ctrl_rd[CB_PHASE] = phase_b;
        ctrl_rd[CB_RUN]   = running;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_CTRL:  rd_data = ctrl_rd;
            SEL_CMPA:  rd_data = cmp_a;
            SEL_CMPB:  rd_data = cmp_b;
            default:   rd_data = cnt;
        endcase
    end

endmodule

// File: tb/test_dc_timer.sv
module test_dc_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        tmr_in = 1'b0;
    logic        pre_tick = 1'b0;
    logic        irq_ack = 1'b0;
    logic        tmr_out, irq, tc_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_on   = 0;
    bit hold     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_timer i_dc_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .tmr_in(tmr_in), .pre_tick(pre_tick), .irq_ack(irq_ack),
        .tmr_out(tmr_out), .irq(irq), .tc_pulse(tc_pulse)
    );

    // behavioural reference
    logic [15:0] m_cnt, m_a, m_b;
    bit m_cont, m_alt, m_ext, m_pre, m_rtg, m_ien;
    bit m_run, m_phb, m_mc, m_irq, m_tc;
    bit m_s1, m_s2, m_s3;
    int m_div;

    always @(posedge clk) begin
        bit rise, base, tk, rt, hitn;
        logic [15:0] cmpv, nxt;
        if (!rst_n) begin
            m_cnt = 0; m_a = 0; m_b = 0;
            {m_cont, m_alt, m_ext, m_pre, m_rtg, m_ien} = '0;
            {m_run, m_phb, m_mc, m_irq, m_tc} = '0;
            {m_s1, m_s2, m_s3} = '0;
            m_div = 0;
        end else begin
            rise = m_s2 && !m_s3;
            base = m_pre ? pre_tick : (m_div == 3);
            tk = 0; rt = 0; hitn = 0;
            if (m_ext) tk = rise;
            else if (m_rtg) begin tk = base; rt = rise; end
            else tk = base && m_s2;
            cmpv = m_phb ? m_b : m_a;
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin
                        m_cont = wr_data[0]; m_alt = wr_data[1]; m_ext = wr_data[2];
                        m_pre = wr_data[3]; m_rtg = wr_data[4]; m_ien = wr_data[6];
                        if (!wr_data[5]) m_mc = 0;
                        if (wr_data[14]) begin
                            if (wr_data[15] && !m_run) begin m_run = 1; m_phb = 0; end
                            else if (!wr_data[15]) begin m_run = 0; m_phb = 0; end
                        end
                    end
                    2'd1: m_a = wr_data;
                    2'd2: m_b = wr_data;
                    default: m_cnt = wr_data;
                endcase
            end else if (m_run) begin
                if (rt) m_cnt = 0;
                else if (tk) begin
                    nxt = m_cnt + 16'd1;
                    if (nxt == cmpv) begin
                        hitn = 1; m_cnt = 0; m_mc = 1;
                        if (m_phb) begin m_phb = 0; if (!m_cont) m_run = 0; end
                        else if (m_alt) m_phb = 1;
                        else if (!m_cont) m_run = 0;
                    end else m_cnt = nxt;
                end
            end
            if (hitn && m_ien) m_irq = 1;
            else if (irq_ack) m_irq = 0;
            m_tc = hitn;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = tmr_in;
            m_div = (m_div + 1) % 4;
        end
    end

    function automatic logic [15:0] model_rd(logic [1:0] s);
        case (s)
            2'd0: return {m_run, 1'b0, 6'b0, m_phb, m_ien, m_mc, m_rtg, m_pre, m_ext, m_alt, m_cont};
            2'd1: return m_a;
            2'd2: return m_b;
            default: return m_cnt;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: got %h expected %h", req, $time, got, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            case (rd_sel)
                2'd0: chk("R2 control readback", rd_data, model_rd(2'd0));
                2'd3: chk("R1 count", rd_data, model_rd(2'd3));
                default: chk("R12 compare readback", rd_data, model_rd(rd_sel));
            endcase
            chk("R3 tmr_out", {15'd0, tmr_out}, {15'd0, (m_alt ? !m_phb : !m_tc)});
            chk("R7 irq", {15'd0, irq}, {15'd0, m_irq});
            chk("R10 tc_pulse", {15'd0, tc_pulse}, {15'd0, m_tc});
            if (!hold) rd_sel <= rd_sel + 2'd1;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_reg(logic [1:0] s, string req);
        @(negedge clk);
        hold = 1; rd_sel = s;
        #3;
        chk(req, rd_data, model_rd(s));
        hold = 0;
    endtask

    function automatic logic [15:0] ctl(bit run, bit inh, bit ien, bit rtg, bit pre,
                                        bit ext, bit alt, bit cont, bit mck = 1'b1);
        return {run, inh, 6'b0, 1'b0, ien, mck, rtg, pre, ext, alt, cont};
    endfunction

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog expired: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk("R11 control after reset", rd_data, 16'h0000);
        chk("R11 tmr_out after reset", {15'd0, tmr_out}, 16'd1);
        chk("R11 irq after reset", {15'd0, irq}, 16'd0);
        chk("R11 tc_pulse after reset", {15'd0, tc_pulse}, 16'd0);
        cmp_on = 1;
        expect_reg(2'd3, "R11 count after reset");
        expect_reg(2'd1, "R11 compare A after reset");

        // R1 single continuous, internal /4 ticks, gate held high
        tmr_in = 1'b1;
        wr(2'd1, 16'd3);
        wr(2'd0, ctl(1,1,0,0,0,0,0,1));
        idle(40);
        expect_reg(2'd3, "R1 modulo-3 count");
        wr(2'd1, 16'd2);
        idle(24);
        expect_reg(2'd3, "R1 modulo-2 count");

        // R2/R3 alternating with interrupts
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd3);
        wr(2'd0, ctl(1,1,1,0,0,0,1,1));
        idle(30);
        expect_reg(2'd0, "R2 phase bit");
        idle(17);
        expect_reg(2'd0, "R2 phase bit later");
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        idle(20);

        // R5 disable, then one-shot runs (R4)
        wr(2'd0, ctl(0,1,0,0,0,0,0,0));
        expect_reg(2'd0, "R5 disable with key");
        wr(2'd3, 16'd0);
        wr(2'd1, 16'd4);
        wr(2'd0, ctl(1,1,0,0,0,0,0,0));
        idle(30);
        expect_reg(2'd0, "R4 single one-shot stopped");
        expect_reg(2'd3, "R4 count left at zero");
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd2);
        wr(2'd0, ctl(1,1,0,0,0,0,1,0));
        idle(30);
        expect_reg(2'd0, "R4 alternating one-shot stopped");

        // R5 write without key leaves running state
        wr(2'd1, 16'd5);
        wr(2'd0, ctl(1,1,0,0,0,0,0,1));
        idle(10);
        wr(2'd0, ctl(0,0,0,0,0,0,0,1));
        expect_reg(2'd0, "R5 no key keeps running");
        idle(30);

        // R6 sticky flag
        wr(2'd0, ctl(0,1,0,0,0,0,0,1,1'b1));
        expect_reg(2'd0, "R6 flag kept on write of 1");
        wr(2'd0, ctl(0,1,0,0,0,0,0,1,1'b0));
        expect_reg(2'd0, "R6 flag cleared on write of 0");

        // R7 irq survives disable
        wr(2'd1, 16'd2);
        wr(2'd0, ctl(1,1,1,0,0,0,0,1));
        idle(12);
        wr(2'd0, ctl(0,1,1,0,0,0,0,1));
        idle(10);
        n_checks++;
        if (irq !== 1'b1) begin
            n_fail++;
            $display("FAIL R7 irq after disable: got %b expected 1", irq);
        end
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        idle(3);

        // R8 external edges
        tmr_in = 1'b0;
        wr(2'd3, 16'd0);
        wr(2'd1, 16'd3);
        wr(2'd0, ctl(1,1,0,0,0,1,0,1));
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); tmr_in = 1'b1;
            idle(3);
            @(negedge clk); tmr_in = 1'b0;
            idle(2);
        end
        idle(5);
        expect_reg(2'd3, "R8 external edge count");
        // R8 prescale tick
        wr(2'd0, ctl(1,1,0,0,1,0,0,1));
        tmr_in = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); pre_tick = (i % 3) != 1;
        end
        @(negedge clk); pre_tick = 1'b0;
        expect_reg(2'd3, "R8 prescale count");

        // R9 gate low holds count
        wr(2'd1, 16'd0);
        wr(2'd0, ctl(1,1,0,0,0,0,0,1));
        idle(10);
        tmr_in = 1'b0;
        idle(20);
        expect_reg(2'd3, "R9 gate low holds");
        tmr_in = 1'b1;
        idle(10);
        // R9 retrigger
        wr(2'd0, ctl(1,1,0,1,0,0,0,1));
        for (int i = 0; i < 4; i++) begin
            idle(9);
            @(negedge clk); tmr_in = 1'b0;
            idle(2);
            @(negedge clk); tmr_in = 1'b1;
        end
        idle(4);
        expect_reg(2'd3, "R9 retrigger clears");

        // R12 count load while running
        wr(2'd0, ctl(1,1,0,0,0,0,0,1));
        wr(2'd3, 16'h1234);
        expect_reg(2'd3, "R12 count load");
        wr(2'd2, 16'hBEEF);
        expect_reg(2'd2, "R12 compare B load");

        // R1 compare 1 and compare 0 (full range) with constant prescale
        wr(2'd0, ctl(0,1,0,0,0,0,0,1));
        wr(2'd3, 16'd0);
        wr(2'd1, 16'd1);
        pre_tick = 1'b1;
        wr(2'd0, ctl(1,1,1,0,1,0,0,1));
        idle(6);
        expect_reg(2'd3, "R1 compare value 1");
        wr(2'd0, ctl(0,1,1,0,1,0,0,1));
        wr(2'd3, 16'd0);
        wr(2'd1, 16'd0);
        wr(2'd0, ctl(1,1,1,0,1,0,0,1,1'b0));
        idle(65534);
        expect_reg(2'd3, "R1 full range near top");
        idle(4);
        expect_reg(2'd0, "R1 full range wrap flag");
        pre_tick = 1'b0;
        idle(4);

        summary();
        $finish;
    end

endmodule